// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block sits on a simple processor bus and offers three byte-wide parallel ports, called A, B and C, plus one configuration register. A chip select, a two-bit address, separate read and write strobes and a byte-wide data bus reach all four locations. Each port has an input from its pins, an output value and a per-bit output enable. For each port, the stored direction decides whether a bus read returns the pin value or the port's own output latch. It also decides whether the output enables are driven.

A write to the configuration address does one of two things, chosen by the top data bit. It either loads a new configuration byte, or it sets or clears one bit of port C. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction. Only basic input/output operation is implemented. The strobed and bidirectional mode fields are kept and can be read back, but they change nothing in the datapath.

Top module: `pio_ctrl`

## Requirements
- R1: The address map is 0 = port A, 1 = port B, 2 = port C, 3 = configuration. A bus write to a port address, on the rising clock edge with chip select and write strobe both high, loads that port's output latch. Each output bus always shows its latch.
- R2: After reset the configuration reads back as 0x9B, all three latches hold 0xFF and every output enable is 0.
- R3: A configuration write with data bit 7 = 1 stores the whole byte. A read of address 3 returns the last stored byte.
- R4: Direction bits in the configuration byte are: bit 4 for port A, bit 1 for port B, bit 3 for the port C upper nibble, bit 0 for the port C lower nibble. A 1 means input and a 0 means output. The enables of an output port or nibble are all 1 and those of an input port or nibble are all 0, starting from the clock edge that stores the byte.
- R5: A configuration byte write clears all three output latches to 0x00.
- R6: A read of an input port or nibble returns the pins. A read of an output port or nibble returns the latch. Port C is selected per nibble.
- R7: A configuration write with bit 7 = 0 takes bits 3:1 as a port C bit index and writes bit 0 into that bit. All other port C bits stay as they were, and the stored configuration byte is unchanged.
- R8: A write to a port configured as input updates its latch, as seen on the output bus, but leaves its enables at 0, and reads still return the pins.
- R9: The mode fields (bits 6:5 and bit 2) are stored and read back, but they do not change latch writes, reads or enables.
- R10: The read data is 0 unless chip select and read strobe are both high, and nothing changes on a write strobe while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSel | input | 1 | Chip select, active high |
| rdStb | input | 1 | Read strobe, active high |
| wrStb | input | 1 | Write strobe, active high |
| addr | input | 2 | Register address |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Bus read data (combinational) |
| portAIn | input | 8 | Port A pin values |
| portAOut | output | 8 | Port A output latch |
| portAOe | output | 8 | Port A output enables |
| portBIn | input | 8 | Port B pin values |
| portBOut | output | 8 | Port B output latch |
| portBOe | output | 8 | Port B output enables |
| portCIn | input | 8 | Port C pin values |
| portCOut | output | 8 | Port C output latch |
| portCOe | output | 8 | Port C output enables |

## Verification
All the state in this block is visible at the ports without delay. A latch shows on its output bus at once, a stored direction shows on the enables in the cycle after the write edge, and a read returns the configuration or the right pin/latch choice in the same cycle. A wrong latch value, a wrong decoded bit index or a lost configuration byte therefore shows as a port mismatch within one clock of the write that caused it. The bench compares enables, output buses and read data against its own model on every clock. Directed sequences cover split nibble directions, bit set/clear, and writes to ports configured as input.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W = 8;
  localparam int IDX_W  = $clog2(PORT_W);

  localparam logic [PORT_W-1:0] CFG_RESET   = 8'h9B;
  localparam logic [PORT_W-1:0] LATCH_RESET = 8'hFF;

  // bit positions inside the configuration byte
  localparam int DIR_CLO = 0;
  localparam int DIR_B   = 1;
  localparam int DIR_CHI = 3;
  localparam int DIR_A   = 4;
  localparam int MODE_FLAG = 7;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CFG = 2'd3
  } pioSel_e;

  typedef struct packed {
    logic             wrA;
    logic             wrB;
    logic             wrC;
    logic             modeWr;
    logic             bitOp;
    logic [IDX_W-1:0] bitIdx;
    logic             bitVal;
    logic             rdEn;
    pioSel_e          rdSel;
  } pioStrobe_t;
endpackage

// File: rtl/pio_control.sv
module pio_control
  import pio_pkg::*;
(
  input  logic              chipSel,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wrData,
  output pioStrobe_t        strb
);
  logic    wrHit;
  pioSel_e sel;

  assign wrHit = chipSel && wrStb;
  assign sel   = pioSel_e'(addr);

  always_comb begin
    strb        = '0;
    strb.wrA    = wrHit && (sel == SEL_A);
    strb.wrB    = wrHit && (sel == SEL_B);
    strb.wrC    = wrHit && (sel == SEL_C);
    strb.modeWr = wrHit && (sel == SEL_CFG) && wrData[MODE_FLAG];
    strb.bitOp  = wrHit && (sel == SEL_CFG) && !wrData[MODE_FLAG];
    strb.bitIdx = wrData[IDX_W:1];
    strb.bitVal = wrData[0];
    strb.rdEn   = chipSel && rdStb;
    strb.rdSel  = sel;
  end

  // at most one write action per cycle
  always_comb begin
    assert_one_action_R1: assert ($onehot0({strb.wrA, strb.wrB, strb.wrC,
                                            strb.modeWr, strb.bitOp}));
  end
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobe_t        strb,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] portAIn,
  input  logic [PORT_W-1:0] portBIn,
  input  logic [PORT_W-1:0] portCIn,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portCOut,
  output logic [PORT_W-1:0] portAOe,
  output logic [PORT_W-1:0] portBOe,
  output logic [PORT_W-1:0] portCOe,
  output logic [PORT_W-1:0] rdData
);
  localparam int HALF_W = PORT_W / 2;

  logic [PORT_W-1:0] cfgReg;
  logic [PORT_W-1:0] latchA, latchB, latchC;
  logic [PORT_W-1:0] viewC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= CFG_RESET;
      latchA <= LATCH_RESET;
      latchB <= LATCH_RESET;
      latchC <= LATCH_RESET;
    end else if (strb.modeWr) begin
      cfgReg <= wrData;
      latchA <= '0;
      latchB <= '0;
      latchC <= '0;
    end else begin
      if (strb.wrA) latchA <= wrData;
      if (strb.wrB) latchB <= wrData;
      if (strb.wrC) latchC <= wrData;
      if (strb.bitOp) latchC[strb.bitIdx] <= strb.bitVal;
    end
  end

  assign portAOut = latchA;
  assign portBOut = latchB;
  assign portCOut = latchC;
  assign portAOe  = {PORT_W{!cfgReg[DIR_A]}};
  assign portBOe  = {PORT_W{!cfgReg[DIR_B]}};

  // port C nibbles carry their own direction
  for (genvar n = 0; n < 2; n++) begin : g_cNib
    localparam int DIR_BIT = (n == 0) ? DIR_CLO : DIR_CHI;
    assign portCOe[n*HALF_W +: HALF_W] = {HALF_W{!cfgReg[DIR_BIT]}};
    assign viewC[n*HALF_W +: HALF_W]   = cfgReg[DIR_BIT] ? portCIn[n*HALF_W +: HALF_W]
                                                          : latchC[n*HALF_W +: HALF_W];
  end

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        SEL_A:   rdData = cfgReg[DIR_A] ? portAIn : latchA;
        SEL_B:   rdData = cfgReg[DIR_B] ? portBIn : latchB;
        SEL_C:   rdData = viewC;
        SEL_CFG: rdData = cfgReg;
        default: rdData = '0;
      endcase
    end
  end

  assert_mode_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWr |=> (portAOut == '0 && portBOut == '0 && portCOut == '0));

  assert_bitop_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitOp |=> $stable(cfgReg));

  assert_bitop_one_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitOp |=> ($countones(portCOut ^ $past(portCOut)) <= 1));

  assert_input_no_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.modeWr && wrData[DIR_A]) |=> (portAOe == '0));
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wrData,
  output logic [PORT_W-1:0] rdData,
  input  logic [PORT_W-1:0] portAIn,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  input  logic [PORT_W-1:0] portBIn,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portBOe,
  input  logic [PORT_W-1:0] portCIn,
  output logic [PORT_W-1:0] portCOut,
  output logic [PORT_W-1:0] portCOe
);
  pioStrobe_t strb;

  pio_control u_control (
    .chipSel (chipSel),
    .rdStb   (rdStb),
    .wrStb   (wrStb),
    .addr    (addr),
    .wrData  (wrData),
    .strb    (strb)
  );

  pio_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .portAIn  (portAIn),
    .portBIn  (portBIn),
    .portCIn  (portCIn),
    .portAOut (portAOut),
    .portBOut (portBOut),
    .portCOut (portCOut),
    .portAOe  (portAOe),
    .portBOe  (portBOe),
    .portCOe  (portCOe),
    .rdData   (rdData)
  );

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(chipSel && rdStb) |-> (rdData == '0));

  assert_no_cs_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> ($stable(portAOut) && $stable(portBOut) && $stable(portCOut)));
endmodule

// File: tb/pio_ctrl_bench.sv
`timescale 1ns/1ps
module pio_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] portAIn = 8'h5A, portBIn = 8'hC6, portCIn = 8'hA3;
  logic [7:0] portAOut, portBOut, portCOut, portAOe, portBOe, portCOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [7:0] mCfg, mA, mB, mC;

  always #2.5 clk = ~clk;

  pio_ctrl u_pio_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .rdStb(rdStb), .wrStb(wrStb),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mCfg[4] ? portAIn : mA;
      2'd1: return mCfg[1] ? portBIn : mB;
      2'd2: return {mCfg[3] ? portCIn[7:4] : mC[7:4], mCfg[0] ? portCIn[3:0] : mC[3:0]};
      default: return mCfg;
    endcase
  endfunction

  function automatic void modelWrite(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: mA = d;
      2'd1: mB = d;
      2'd2: mC = d;
      default:
        if (d[7]) begin mCfg = d; mA = 8'h00; mB = 8'h00; mC = 8'h00; end
        else mC[d[3:1]] = d[0];
    endcase
  endfunction

  // every-clock comparison of enables, output buses and read data
  always @(negedge clk) begin
    if (rstN && !done) begin
      #1;
      chk("R4 oeA", portAOe, mCfg[4] ? 8'h00 : 8'hFF);
      chk("R4 oeB", portBOe, mCfg[1] ? 8'h00 : 8'hFF);
      chk("R4 oeC", portCOe, {mCfg[3] ? 4'h0 : 4'hF, mCfg[0] ? 4'h0 : 4'hF});
      chk("R1 outA", portAOut, mA);
      chk("R1 outB", portBOut, mB);
      chk("R1 outC", portCOut, mC);
      chk("R6 R10 rd", rdData, (chipSel && rdStb) ? expRead(addr) : 8'h00);
    end
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input bit sel = 1'b1);
    @(negedge clk);
    chipSel = sel; wrStb = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1;
    if (sel) modelWrite(a, d);
    @(negedge clk);
    chipSel = 1'b0; wrStb = 1'b0;
  endtask

  task automatic busRead(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    chipSel = 1'b1; rdStb = 1'b1; addr = a;
    #1;
    chk(tag, rdData, exp);
    @(negedge clk);
    chipSel = 1'b0; rdStb = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mCfg = 8'h9B; mA = 8'hFF; mB = 8'hFF; mC = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R2: reset state
    chk("R2 outA", portAOut, 8'hFF);
    chk("R2 oeC", portCOe, 8'h00);
    busRead("R2 cfg", 2'd3, 8'h9B);
    busRead("R6 input A pins", 2'd0, 8'h5A);

    // R3 R5: all outputs
    busWrite(2'd3, 8'h80);
    busRead("R3 cfg", 2'd3, 8'h80);
    chk("R5 latchC cleared", portCOut, 8'h00);
    chk("R4 oeA out", portAOe, 8'hFF);

    // R1: port writes and read back
    busWrite(2'd0, 8'h3C);
    busWrite(2'd1, 8'hC3);
    busWrite(2'd2, 8'h81);
    busRead("R1 A", 2'd0, 8'h3C);
    busRead("R1 B", 2'd1, 8'hC3);
    busRead("R1 C", 2'd2, 8'h81);

    // R7: bit set / clear
    busWrite(2'd3, 8'h0B);
    busRead("R7 set bit5", 2'd2, 8'hA1);
    busWrite(2'd3, 8'h00);
    busRead("R7 clear bit0", 2'd2, 8'hA0);
    busWrite(2'd3, 8'h0E);
    busRead("R7 clear bit7", 2'd2, 8'h20);
    busRead("R7 cfg kept", 2'd3, 8'h80);

    // R6: split nibbles, upper input lower output
    busWrite(2'd3, 8'h88);
    busWrite(2'd2, 8'h5F);
    busRead("R6 C split", 2'd2, 8'hAF);
    chk("R4 oeC split", portCOe, 8'h0F);
    portCIn = 8'h3C;
    busRead("R6 C split pins", 2'd2, 8'h3F);

    // R8: writes to input ports
    busWrite(2'd3, 8'h92);
    busWrite(2'd0, 8'h77);
    chk("R8 latch A", portAOut, 8'h77);
    chk("R8 oeA low", portAOe, 8'h00);
    busRead("R8 read pins A", 2'd0, 8'h5A);
    busWrite(2'd1, 8'h19);
    busRead("R8 read pins B", 2'd1, 8'hC6);

    // R9: mode fields stored, no effect
    busWrite(2'd3, 8'hE4);
    busRead("R9 cfg", 2'd3, 8'hE4);
    busWrite(2'd0, 8'h11);
    busRead("R9 A latch", 2'd0, 8'h11);
    chk("R9 oeB", portBOe, 8'hFF);

    // R10: no chip select
    busWrite(2'd0, 8'hEE, 1'b0);
    busWrite(2'd3, 8'h9B, 1'b0);
    chk("R10 A kept", portAOut, 8'h11);
    busRead("R10 cfg kept", 2'd3, 8'hE4);
    @(negedge clk);
    rdStb = 1'b1; addr = 2'd3;
    #1;
    chk("R10 read without cs", rdData, 8'h00);
    rdStb = 1'b0;

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule